// File: doc/BRIEF.md
# Sync-Aligned Integer Clock Divider

This block divides a fast clock by a programmable integer ratio and produces a one-cycle enable, `div_en_o`, that downstream logic uses as a divided clock. Several such dividers, in one chip or in several, can be brought into the same phase by an external sync pulse. The pulse enters through a two-flop synchronizer. Its rising edge, once qualified by a small control register, restarts the divider count from zero.

The control register is written through a single-cycle write port and can be read back at any time. Only its three low bits are implemented. The master bit and the divider-sync bit together decide whether sync events reach the divider. A third bit picks between two modes. In continuous mode every qualified event realigns the divider. In one-shot mode only the first event does, and the hardware then clears the divider-sync bit, so later pulses are ignored until software sets the bit again.

A one-hot-free, three-state arming machine follows the register. Its states are ARM_OFF (sync gated off), ARM_CONT (continuous) and ARM_ONCE (armed for one pulse). Every register write moves the machine to the state that the written value decodes to: OFF, CONT or ONCE. A qualified event in ARM_ONCE with no write in the same cycle moves it to ARM_OFF; this is the self-clear. A qualified event in ARM_CONT keeps it in ARM_CONT. Events in ARM_OFF have no effect.

Top module: `clkdiv_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, `reg_rdata_o` is 0x00, `sync_taken_o` is 0 and the divider count is 0. After release, the first `div_en_o` pulse therefore appears once `div_ratio_i` further rising edges have passed.
- R2: `reg_rdata_o[7:3]` always reads 0, and the values written to those bits have no effect.
- R3: A write (`reg_wr_i` high at a rising edge) shows on `reg_rdata_o` from the next cycle as `reg_wdata_i & 8'h07`.
- R4: With bit 0 (master enable) at 0, sync pulses neither realign the divider nor raise `sync_taken_o`.
- R5: With bit 1 (divider sync enable) at 0, sync pulses neither realign the divider nor raise `sync_taken_o`.
- R6: `sync_i` is taken through two flops and acts on its rising edge only. A pulse that is raised just after one edge of `clk` realigns the divider at the third edge, and a pulse held high for many cycles counts once.
- R7: With bits [2:0] = 3'b011 (continuous mode), every qualified sync event realigns the divider and the register stays unchanged.
- R8: With bits [2:0] = 3'b111 (one-shot mode), the first qualified event realigns the divider and clears bit 1, so the register reads 0x05. Later pulses are ignored.
- R9: When a register write falls in the same cycle as the one-shot self-clear, the written value is stored.
- R10: `div_ratio_i` = v selects division by v+1, giving ratios 1 to 8. `div_en_o` is high when the count equals v, which is the last count before it wraps to 0. With v = 0, `div_en_o` stays high.
- R11: A realignment sets the count to 0 in the cycle after the event. `div_en_o` is then next high v cycles later and repeats every v+1 cycles.
- R12: `sync_taken_o` is high for exactly one cycle, the cycle after each realigning event, and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low reset |
| sync_i | input | 1 | Asynchronous sync pulse |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| div_ratio_i | input | 3 | Divide ratio minus one |
| div_en_o | output | 1 | Divided clock enable |
| reg_rdata_o | output | 8 | Control register readback |
| sync_taken_o | output | 1 | One-cycle flag: divider realigned |

## Verification
A wrong arming state shows at the ports at the very next sync event. Either `sync_taken_o` fails to pulse, or it pulses when it should not. In both cases the `div_en_o` grid lands in a different phase from the one predicted by counting from the event, and every later enable repeats that error. A self-clear that is missing or spurious also shows on `reg_rdata_o` one cycle after the event. A corrupted divider count shifts the next enable by up to seven cycles, which the bench catches within one divide period by comparing against a grid it derives from the cycle of the sync or of a known enable.

// File: rtl/cds_pkg.sv
package cds_pkg;
    // Arming state of the sync gate
    typedef enum logic [1:0] {
        ARM_OFF  = 2'd0,
        ARM_CONT = 2'd1,
        ARM_ONCE = 2'd2
    } arm_state_t;

    // Control register bit positions (decoded by the arming logic)
    localparam int unsigned CTL_MASTER = 0;
    localparam int unsigned CTL_DIVEN  = 1;
    localparam int unsigned CTL_ONCE   = 2;
    localparam int unsigned CTL_USED   = 3;
endpackage

// File: rtl/cds_sync.sv
module cds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cds_ctrl.sv
module cds_ctrl
    import cds_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             rise_i,
    output logic             realign_o,
    output logic             taken_o,
    output logic [CTL_W-1:0] rdata_o
);
    localparam logic [CTL_W-1:0] RW_MASK = CTL_W'((1 << CTL_USED) - 1);

    arm_state_t       state_q, state_d;
    logic [CTL_W-1:0] ctl_q, ctl_d;
    logic             self_clear;

    function automatic arm_state_t mode_of(input logic [CTL_W-1:0] v);
        if (!(v[CTL_MASTER] && v[CTL_DIVEN])) return ARM_OFF;
        else if (v[CTL_ONCE])                 return ARM_ONCE;
        else                                  return ARM_CONT;
    endfunction

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_OFF: begin
                if (wr_i) state_d = mode_of(ctl_d);
            end
            ARM_CONT: begin
                if (wr_i) state_d = mode_of(ctl_d);
            end
            ARM_ONCE: begin
                if (wr_i)         state_d = mode_of(ctl_d);
                else if (rise_i)  state_d = ARM_OFF;
            end
            default: state_d = ARM_OFF;
        endcase
    end

    // Output / datapath process
    always_comb begin
        realign_o  = rise_i && (state_q != ARM_OFF);
        self_clear = realign_o && (state_q == ARM_ONCE);
        ctl_d      = ctl_q;
        if (self_clear) ctl_d[CTL_DIVEN] = 1'b0;
        if (wr_i)       ctl_d = wdata_i & RW_MASK;
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_OFF;
            ctl_q   <= '0;
            taken_o <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
            taken_o <= realign_o;
        end
    end

    assign rdata_o = ctl_q;
endmodule

// File: rtl/cds_divider.sv
module cds_divider #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_m1_i,
    input  logic               realign_i,
    output logic               tick_o
);
    logic [RATIO_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (realign_i)                cnt_d = '0;
        else if (cnt_q >= ratio_m1_i) cnt_d = '0;
        else                          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == ratio_m1_i);
endmodule

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl #(
    parameter int CTL_W       = 8,
    parameter int RATIO_W     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic               reg_wr_i,
    input  logic [CTL_W-1:0]   reg_wdata_i,
    input  logic [RATIO_W-1:0] div_ratio_i,
    output logic               div_en_o,
    output logic [CTL_W-1:0]   reg_rdata_o,
    output logic               sync_taken_o
);
    logic sync_rise;
    logic realign;

    cds_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_i),
        .rise_o  (sync_rise)
    );

    cds_ctrl #(.CTL_W(CTL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .rise_i    (sync_rise),
        .realign_o (realign),
        .taken_o   (sync_taken_o),
        .rdata_o   (reg_rdata_o)
    );

    cds_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_m1_i (div_ratio_i),
        .realign_i  (realign),
        .tick_o     (div_en_o)
    );
endmodule

// File: rtl/cds_checker.sv
module cds_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [2:0] div_ratio_i,
    input logic       div_en_o,
    input logic [7:0] reg_rdata_o,
    input logic       sync_taken_o
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[7:3] == 5'd0);

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> reg_rdata_o == ($past(reg_wdata_i) & 8'h07));

    assert_gate_needs_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_taken_o |-> $past(reg_rdata_o[1:0]) == 2'b11);

    assert_oneshot_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_taken_o && $past(reg_rdata_o[2]) && !$past(reg_wr_i)) |-> !reg_rdata_o[1]);

    assert_ratio_one_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ratio_i == 3'd0 && $past(div_ratio_i) == 3'd0) |-> div_en_o);

    assert_en_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en_o && div_ratio_i != 3'd0) |=> (!div_en_o || div_ratio_i != $past(div_ratio_i)));

    assert_taken_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sync_taken_o |=> !sync_taken_o);
endmodule

bind clkdiv_sync_ctrl cds_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .div_ratio_i  (div_ratio_i),
    .div_en_o     (div_en_o),
    .reg_rdata_o  (reg_rdata_o),
    .sync_taken_o (sync_taken_o)
);

// File: tb/sim_clkdiv_sync_ctrl.sv
`timescale 1ns/1ps
module sim_clkdiv_sync_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [2:0] ratio = 3'd3;
    logic       div_en;
    logic [7:0] rdata;
    logic       taken;

    int n_run = 0;
    int n_fail = 0;
    int ncyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) ncyc <= ncyc + 1;

    clkdiv_sync_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_in),
        .reg_wr_i     (wr),
        .reg_wdata_i  (wdata),
        .div_ratio_i  (ratio),
        .div_en_o     (div_en),
        .reg_rdata_o  (rdata),
        .sync_taken_o (taken)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic find_hi(output int t);
        t = -1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (div_en) begin t = ncyc; break; end
        end
        chk(t >= 0, "R10 enable seen", t, 0);
    endtask

    // ref: a cycle in which the count is 0
    task automatic check_grid(input int ref_c, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int exp;
            @(negedge clk);
            exp = (((ncyc - ref_c) % (int'(ratio) + 1)) == int'(ratio)) ? 1 : 0;
            chk(int'(div_en) == exp, req, int'(div_en), exp);
        end
    endtask

    task automatic pulse(input int len, input bit exp_taken, input bit collide, output int ref_c);
        int hits = 0;
        ref_c = 0;
        @(negedge clk); sync_in = 1'b1;
        for (int i = 1; i <= len + 4; i++) begin
            @(negedge clk);
            if (taken) begin
                hits++;
                chk(i == 3, "R6 sync latency", i, 3);
            end
            if (i == 3) ref_c = ncyc;
            if (collide && i == 2) begin wr = 1'b1; wdata = 8'h07; end
            if (collide && i == 3) wr = 1'b0;
            if (i == len) sync_in = 1'b0;
        end
        chk(hits == (exp_taken ? 1 : 0), "R12 taken count", hits, exp_taken ? 1 : 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rdata == 8'h00, "R1 reset readback", rdata, 0);
        chk(taken == 1'b0, "R1 reset taken", taken, 0);
        chk(div_en == 1'b0, "R1 reset enable", div_en, 0);
        rst_n = 1'b1;
        check_grid(ncyc, 12, "R1 first period");
    endtask

    task automatic t_reserved();
        write_reg(8'hF8);
        chk(rdata == 8'h00, "R2 reserved write", rdata, 0);
        write_reg(8'hFF);
        chk(rdata == 8'h07, "R2 R3 masked readback", rdata, 7);
        write_reg(8'h00);
        chk(rdata == 8'h00, "R3 clear", rdata, 0);
    endtask

    task automatic t_gated(input logic [7:0] v, input string req);
        int t, d;
        write_reg(v);
        ratio = 3'd2;
        repeat (4) @(negedge clk);
        find_hi(t);
        pulse(5, 1'b0, 1'b0, d);
        check_grid(t + 1, 12, req);
        chk(rdata == v, req, rdata, v);
    endtask

    task automatic t_continuous();
        int t, r;
        write_reg(8'h03);
        ratio = 3'd4;
        repeat (6) @(negedge clk);
        find_hi(t);
        pulse(8, 1'b1, 1'b0, r);
        check_grid(r, 12, "R11 realign continuous");
        chk(rdata == 8'h03, "R7 register kept", rdata, 3);
        repeat (2) @(negedge clk);
        pulse(3, 1'b1, 1'b0, r);
        check_grid(r, 12, "R7 second realign");
    endtask

    task automatic t_oneshot();
        int r, d;
        write_reg(8'h07);
        ratio = 3'd5;
        repeat (3) @(negedge clk);
        pulse(4, 1'b1, 1'b0, r);
        chk(rdata == 8'h05, "R8 self clear", rdata, 5);
        check_grid(r, 8, "R11 realign one-shot");
        pulse(4, 1'b0, 1'b0, d);
        check_grid(r, 14, "R8 later pulse ignored");
    endtask

    task automatic t_collide();
        int r;
        write_reg(8'h07);
        pulse(4, 1'b1, 1'b1, r);
        chk(rdata == 8'h07, "R9 write wins", rdata, 7);
        pulse(4, 1'b1, 1'b0, r);
        chk(rdata == 8'h05, "R9 rearmed then cleared", rdata, 5);
    endtask

    task automatic t_ratios();
        int t;
        ratio = 3'd0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(div_en == 1'b1, "R10 ratio one", div_en, 1);
        end
        ratio = 3'd7;
        find_hi(t);
        check_grid(t + 1, 20, "R10 ratio eight");
    endtask

    initial begin
        t_reset();
        t_reserved();
        t_gated(8'h02, "R4 master off");
        t_gated(8'h05, "R5 divider sync off");
        t_continuous();
        t_oneshot();
        t_collide();
        t_ratios();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule